// File: doc/BRIEF.md
# Configurable Output Macrocell

One output cell of a registered sum-of-products logic device. It receives the OR-sum that the logic array built for this output, a per-cell output-enable term, and the device-wide clock, synchronous preset and asynchronous clear terms. From these it drives a pin data value, a pin drive enable and one feedback signal that returns to the array.

A four-bit configuration word selects three things independently:

- the output polarity;
- whether the pin shows the flip-flop or the raw sum;
- which of three sources feeds back to the array: the flip-flop, the raw sum, or the pin.

A mode input limits the cell to a four-configuration compatibility subset. In that subset the feedback source follows the output type. With the mode input set, the full twelve-configuration set is available.

Top module: `out_macrocell`

## Requirements
- R1: While `clr_term` is high, the flip-flop holds 0. It drops to 0 as soon as `clr_term` rises, with no clock edge needed. Clear takes priority over preset.
- R2: On a rising `clk` edge with `clr_term` low and `preset_term` high, the flip-flop becomes 1 whatever `sum_in` is.
- R3: On a rising `clk` edge with `clr_term` and `preset_term` both low, the flip-flop takes the value of `sum_in`.
- R4: Configuration bit 1 selects the pin data source. When it is 1 the flip-flop is used; when it is 0 the current `sum_in` is used combinationally.
- R5: Configuration bit 0 sets polarity. When it is 1 the selected data is inverted at `pin_out`; when it is 0 it passes unchanged.
- R6: `pin_oe` equals `oe_term` in every configuration and mode.
- R7: With `ext_mode`=1, configuration bits 3:2 pick the feedback: 00 gives the flip-flop, 01 gives `sum_in`, and 10 or 11 give `pin_in`.
- R8: With `ext_mode`=0, configuration bits 3:2 are ignored. Feedback is the flip-flop when bit 1 is 1, and `pin_in` when bit 1 is 0.
- R9: Flip-flop feedback is the uninverted register value, whatever the setting of polarity bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock term, rising edge |
| clr_term | input | 1 | Global asynchronous clear, active high |
| preset_term | input | 1 | Global synchronous preset, active high |
| sum_in | input | 1 | OR-sum for this cell |
| oe_term | input | 1 | Output-enable product term |
| pin_in | input | 1 | Value present on the pin |
| cfg | input | 4 | Configuration word: bit0 polarity, bit1 registered, bits3:2 feedback |
| ext_mode | input | 1 | 1 selects the extended twelve-configuration set |
| pin_out | output | 1 | Data to the pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback to the logic array |

## Verification
The hardest case to reach is a clear that arrives between clock edges. Its effect has to be seen before any edge could explain it. The stimulus selects flip-flop feedback in the extended set and loads a 1 with `sum_in`. It then raises `clr_term` halfway through a clock phase and samples `fb_out` before the next rising edge. Every remaining combination of mode, configuration word, sum, pin and enable is swept with the flip-flop held in both states, so that a wrong source or a lost inversion shows up.

// File: rtl/out_macrocell.sv
module out_macrocell #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             clr_term,
  input  logic             preset_term,
  input  logic             sum_in,
  input  logic             oe_term,
  input  logic             pin_in,
  input  logic [CFG_W-1:0] cfg,
  input  logic             ext_mode,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);

  localparam logic [1:0] FB_REG = 2'b00;
  localparam logic [1:0] FB_SUM = 2'b01;
  localparam logic [1:0] FB_PIN = 2'b10;

  logic       q;
  logic       inv_sel;
  logic       reg_sel;
  logic [1:0] fb_cfg;
  logic [1:0] fb_sel;
  logic       data_sel;

  assign inv_sel = cfg[0];
  assign reg_sel = cfg[1];
  assign fb_cfg  = cfg[3:2];

  always_ff @(posedge clk or posedge clr_term) begin
    if (clr_term)         q <= 1'b0;
    else if (preset_term) q <= 1'b1;
    else                  q <= sum_in;
  end

  assign data_sel = reg_sel ? q : sum_in;
  assign pin_out  = data_sel ^ inv_sel;
  assign pin_oe   = oe_term;

  always_comb begin
    if (ext_mode)     fb_sel = fb_cfg;
    else if (reg_sel) fb_sel = FB_REG;
    else              fb_sel = FB_PIN;
  end

  always_comb begin
    case (fb_sel)
      FB_REG:  fb_out = q;
      FB_SUM:  fb_out = sum_in;
      default: fb_out = pin_in;
    endcase
  end

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (clr_term)
    preset_term |=> q); // R2
  AST_D_LOADS: assert property (@(posedge clk) disable iff (clr_term)
    !preset_term |=> (q == $past(sum_in))); // R3
  AST_COMPAT_REG_FB: assert property (@(posedge clk) disable iff (clr_term)
    (!ext_mode && cfg[1]) |-> (fb_out == q)); // R8
  AST_COMPAT_PIN_FB: assert property (@(posedge clk) disable iff (clr_term)
    (!ext_mode && !cfg[1]) |-> (fb_out == pin_in)); // R8
  AST_EXT_SUM_FB: assert property (@(posedge clk) disable iff (clr_term)
    (ext_mode && cfg[3:2] == 2'b01) |-> (fb_out == sum_in)); // R7
  AST_REG_FB_RAW: assert property (@(posedge clk) disable iff (clr_term)
    (ext_mode && cfg[3:2] == 2'b00 && cfg[1]) |-> (pin_out == (fb_out ^ cfg[0]))); // R9
  AST_OE_PASS: assert property (@(posedge clk) disable iff (clr_term)
    pin_oe == oe_term); // R6

endmodule

// File: tb/out_macrocell_tb_top.sv
`timescale 1ns/1ps
module out_macrocell_tb_top;
  logic clk = 1'b0;
  logic clr_term, preset_term, sum_in, oe_term, pin_in, ext_mode;
  logic [3:0] cfg;
  logic pin_out, pin_oe, fb_out;
  logic qm;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  out_macrocell dut_i (
    .clk(clk), .clr_term(clr_term), .preset_term(preset_term), .sum_in(sum_in),
    .oe_term(oe_term), .pin_in(pin_in), .cfg(cfg), .ext_mode(ext_mode),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  always @(posedge clk or posedge clr_term) begin
    if (clr_term)         qm <= 1'b0;
    else if (preset_term) qm <= 1'b1;
    else                  qm <= sum_in;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b cfg=%b ext=%b", tag, act, exp, cfg, ext_mode);
    end
  endtask

  task automatic check_all();
    logic data, pexp, fexp;
    logic [1:0] sel;
    string ftag;
    data = cfg[1] ? qm : sum_in;
    pexp = data ^ cfg[0];
    sel  = ext_mode ? cfg[3:2] : (cfg[1] ? 2'b00 : 2'b10);
    fexp = (sel == 2'b00) ? qm : (sel == 2'b01) ? sum_in : pin_in;
    ftag = ext_mode ? "R7" : "R8";
    if (sel == 2'b00 && cfg[0]) ftag = "R9";
    chk(cfg[0] ? "R5" : "R4", pin_out, pexp);
    chk("R6", pin_oe, oe_term);
    chk(ftag, fb_out, fexp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_term = 1'b1; preset_term = 1'b0; sum_in = 1'b0; oe_term = 1'b0;
    pin_in = 1'b0; ext_mode = 1'b1; cfg = 4'b0010;
    #1;
    chk("R1", fb_out, 1'b0);
    repeat (2) @(negedge clk);
    chk("R1", fb_out, 1'b0);
    clr_term = 1'b0;

    // R3 loads, R2 preset
    sum_in = 1'b1; @(negedge clk); chk("R3", fb_out, 1'b1);
    sum_in = 1'b0; @(negedge clk); chk("R3", fb_out, 1'b0);
    preset_term = 1'b1; @(negedge clk); chk("R2", fb_out, 1'b1);
    chk("R2", pin_out, 1'b1);
    preset_term = 1'b0;
    // R1 mid-cycle clear with no edge, then clear beats preset
    sum_in = 1'b1; @(negedge clk); chk("R3", fb_out, 1'b1);
    #2 clr_term = 1'b1; #1; chk("R1", fb_out, 1'b0);
    preset_term = 1'b1;
    @(negedge clk); chk("R1", fb_out, 1'b0);
    clr_term = 1'b0; preset_term = 1'b0; sum_in = 1'b0;
    @(negedge clk);

    // full sweep: register state, mode, cfg, sum, pin, oe
    for (int qs = 0; qs < 2; qs++) begin
      for (int m = 0; m < 2; m++) begin
        for (int c = 0; c < 16; c++) begin
          for (int v = 0; v < 8; v++) begin
            preset_term = qs[0]; sum_in = 1'b0;
            @(negedge clk);
            preset_term = 1'b0;
            ext_mode = m[0]; cfg = c[3:0];
            sum_in = v[0]; pin_in = v[1]; oe_term = v[2];
            #2;
            check_all();
            @(negedge clk);
            if (!ext_mode && cfg[1]) chk("R8", fb_out, sum_in);
          end
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule